// File: doc/BRIEF.md
# MSI Vector Capture and Interrupt Aggregator

This block sits beside the inbound write path of a PCIe root port. Every inbound memory write is presented to it as a single-cycle strobe with a 64-bit address and a 32-bit data word. When the address equals a software-programmed 64-bit target, the data word is taken as a vector number. The block then sets the matching sticky status bit, but only if that vector is enabled.

Vectors are grouped into banks of 32. Each bank has its own enable, mask and status word. Status bits are cleared by writing ones to them. A masked vector still records its event, but it cannot raise the host interrupt. The single interrupt output is a registered OR of every status bit whose mask bit is clear. Software reaches all of this through a 32-bit register port. A read returns its data one cycle after the read strobe.

Top module: `msi_irq_ctrl`

## Requirements
- R1: After reset every enable, mask and status bit is 0, the target address is 0, `irq` is 0 and `reg_rdata` is 0.
- R2: The low 32 bits of the target address are written and read at offset 0x820, and the high 32 bits at offset 0x824.
- R3: Bank b is reached at three offsets: enable at 0x828 + 12*b, mask at 0x82C + 12*b and status at 0x830 + 12*b. Enable and mask read back exactly what was written.
- R4: A strobe whose address equals the target and whose data n is below 32*NUM_BANKS sets status bit n%32 of bank n/32 at the next clock edge, provided that vector's enable bit is 1.
- R5: A strobe to the target for a vector whose enable bit is 0 leaves all status unchanged.
- R6: A strobe to any address other than the target leaves all status unchanged.
- R7: A strobe carrying data of 32*NUM_BANKS or more leaves all status unchanged, even when its low bits name an enabled vector.
- R8: Writing the status register of a bank clears each bit written with 1 and leaves each bit written with 0 unchanged.
- R9: If a vector's set event and a clear of that same bit fall in the same cycle, the bit ends up set. Other bits in the clear still clear.
- R10: `irq` equals, one cycle later, the OR over all vectors of (status AND NOT mask). A masked vector still sets its status bit.
- R11: `reg_rdata` holds the addressed register's value from the edge that samples `reg_rd`. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| in_wr_valid | input | 1 | Inbound memory write strobe |
| in_wr_addr | input | 64 | Inbound write address |
| in_wr_data | input | 32 | Inbound write data (vector number) |
| irq | output | 1 | Aggregated interrupt to the host |

## Verification
Two functions can land on one status bit in the same clock edge: an inbound vector write that sets the bit, and a write-one-to-clear from software. The bench provokes this by driving both strobes in one cycle. Bank 0 is cleared with all ones while an inbound write targets vector 3, and another pending vector 5 is present. It then reads the status back and expects only bit 3, which shows that the set survived while the other cleared bit went away.

// File: rtl/msi_ctrl_pkg.sv
package msi_ctrl_pkg;
  localparam int unsigned VEC_PER_BANK = 32;
  localparam int unsigned TGT_LO_OFS   = 'h820;
  localparam int unsigned TGT_HI_OFS   = 'h824;
  localparam int unsigned BANK_BASE    = 'h828;
  localparam int unsigned BANK_STRIDE  = 12;
  localparam int unsigned EN_OFS       = 0;
  localparam int unsigned MASK_OFS     = 4;
  localparam int unsigned STAT_OFS     = 8;

  function automatic int unsigned bank_reg_ofs(input int unsigned bank, input int unsigned field);
    return BANK_BASE + BANK_STRIDE * bank + field;
  endfunction
endpackage

// File: rtl/msi_addr_match.sv
module msi_addr_match #(
  parameter int NUM_VEC = 64,
  localparam int IDX_W  = $clog2(NUM_VEC)
) (
  input  logic               valid,
  input  logic [63:0]        addr,
  input  logic [31:0]        data,
  input  logic [63:0]        target,
  output logic [NUM_VEC-1:0] set_vec
);
  logic hit;
  logic in_range;
  logic [IDX_W-1:0] idx;

  assign hit      = valid && (addr == target);
  assign in_range = data < 32'(NUM_VEC);
  assign idx      = data[IDX_W-1:0];

  always_comb begin
    set_vec = '0;
    if (hit && in_range) set_vec[idx] = 1'b1;
  end
endmodule

// File: rtl/msi_vec_bank.sv
module msi_vec_bank #(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_we,
  input  logic              mask_we,
  input  logic              stat_we,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] set_req,
  output logic [BANK_W-1:0] enable,
  output logic [BANK_W-1:0] mask,
  output logic [BANK_W-1:0] status,
  output logic              pend
);
  logic [BANK_W-1:0] clr;
  logic [BANK_W-1:0] set_ok;

  assign clr    = stat_we ? wdata : '0;
  assign set_ok = set_req & enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= '0;
      mask   <= '0;
      status <= '0;
    end else begin
      if (en_we)   enable <= wdata;
      if (mask_we) mask   <= wdata;
      // set has priority over a simultaneous clear
      status <= (status & ~clr) | set_ok;
    end
  end

  assign pend = |(status & ~mask);
endmodule

// File: rtl/msi_irq_ctrl.sv
module msi_irq_ctrl
  import msi_ctrl_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 12,
  localparam int NUM_VEC  = NUM_BANKS * VEC_PER_BANK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              in_wr_valid,
  input  logic [63:0]       in_wr_addr,
  input  logic [31:0]       in_wr_data,
  output logic              irq
);
  logic [63:0]          target_q;
  logic [NUM_VEC-1:0]   set_vec;
  logic [NUM_VEC-1:0]   en_all;
  logic [NUM_VEC-1:0]   mask_all;
  logic [NUM_VEC-1:0]   stat_all;
  logic [NUM_BANKS-1:0] pend_b;
  logic [31:0]          rd_mux;

  msi_addr_match #(.NUM_VEC(NUM_VEC)) u_match (
    .valid   (in_wr_valid),
    .addr    (in_wr_addr),
    .data    (in_wr_data),
    .target  (target_q),
    .set_vec (set_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      target_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_W'(TGT_LO_OFS)) target_q[31:0]  <= reg_wdata;
      if (reg_addr == ADDR_W'(TGT_HI_OFS)) target_q[63:32] <= reg_wdata;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned EN_A   = bank_reg_ofs(b, EN_OFS);
    localparam int unsigned MASK_A = bank_reg_ofs(b, MASK_OFS);
    localparam int unsigned STAT_A = bank_reg_ofs(b, STAT_OFS);
    logic en_we, mask_we, stat_we;
    assign en_we   = reg_wr && (reg_addr == ADDR_W'(EN_A));
    assign mask_we = reg_wr && (reg_addr == ADDR_W'(MASK_A));
    assign stat_we = reg_wr && (reg_addr == ADDR_W'(STAT_A));

    msi_vec_bank #(.BANK_W(VEC_PER_BANK)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .en_we   (en_we),
      .mask_we (mask_we),
      .stat_we (stat_we),
      .wdata   (reg_wdata),
      .set_req (set_vec[b*VEC_PER_BANK +: VEC_PER_BANK]),
      .enable  (en_all[b*VEC_PER_BANK +: VEC_PER_BANK]),
      .mask    (mask_all[b*VEC_PER_BANK +: VEC_PER_BANK]),
      .status  (stat_all[b*VEC_PER_BANK +: VEC_PER_BANK]),
      .pend    (pend_b[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(TGT_LO_OFS)) rd_mux = target_q[31:0];
    if (reg_addr == ADDR_W'(TGT_HI_OFS)) rd_mux = target_q[63:32];
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reg_addr == ADDR_W'(bank_reg_ofs(b, EN_OFS)))
        rd_mux = en_all[b*VEC_PER_BANK +: VEC_PER_BANK];
      if (reg_addr == ADDR_W'(bank_reg_ofs(b, MASK_OFS)))
        rd_mux = mask_all[b*VEC_PER_BANK +: VEC_PER_BANK];
      if (reg_addr == ADDR_W'(bank_reg_ofs(b, STAT_OFS)))
        rd_mux = stat_all[b*VEC_PER_BANK +: VEC_PER_BANK];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      irq <= |pend_b;
    end
  end
endmodule

// File: rtl/msi_irq_ctrl_chk.sv
module msi_irq_ctrl_chk #(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 12,
  localparam int NUM_VEC  = NUM_BANKS * 32,
  localparam int IDX_W    = $clog2(NUM_VEC)
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [31:0]        reg_wdata,
  input logic               in_wr_valid,
  input logic [63:0]        in_wr_addr,
  input logic [31:0]        in_wr_data,
  input logic [63:0]        target,
  input logic [NUM_VEC-1:0] en_all,
  input logic [NUM_VEC-1:0] mask_all,
  input logic [NUM_VEC-1:0] stat_all,
  input logic               irq
);
  // R4 and R9: an enabled hit always leaves its bit set
  p_set_r4: assert property (@(posedge clk) disable iff (rst)
    (in_wr_valid && in_wr_addr == target && in_wr_data < 32'(NUM_VEC)
     && en_all[in_wr_data[IDX_W-1:0]])
    |=> stat_all[$past(in_wr_data[IDX_W-1:0])]);

  // R6: no new status bits without a strobe to the target
  p_no_stray_set_r6: assert property (@(posedge clk) disable iff (rst)
    (!in_wr_valid || in_wr_addr != target)
    |=> (stat_all & ~$past(stat_all)) == '0);

  // R8: status bits fall only on a register write
  p_clear_only_by_write_r8: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> (~stat_all & $past(stat_all)) == '0);

  // R8: all-ones clear of bank 0 without a strobe empties bank 0
  p_w1c_bank0_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'('h830) && reg_wdata == '1 && !in_wr_valid)
    |=> stat_all[31:0] == '0);

  // R10: interrupt is the registered unmasked pending OR
  p_irq_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(|(stat_all & ~mask_all)));
endmodule

bind msi_irq_ctrl msi_irq_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .in_wr_valid (in_wr_valid),
  .in_wr_addr  (in_wr_addr),
  .in_wr_data  (in_wr_data),
  .target      (target_q),
  .en_all      (en_all),
  .mask_all    (mask_all),
  .stat_all    (stat_all),
  .irq         (irq)
);

// File: tb/msi_irq_ctrl_test.sv
module msi_irq_ctrl_test;
  localparam int ADDR_W = 12;
  localparam logic [63:0] TGT = 64'h0000_00AB_FEE0_1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic in_wr_valid = 1'b0;
  logic [63:0] in_wr_addr = '0;
  logic [31:0] in_wr_data = '0;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  msi_irq_ctrl #(.NUM_BANKS(2), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_wr_valid(in_wr_valid),
    .in_wr_addr(in_wr_addr), .in_wr_data(in_wr_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic msi_send(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk); in_wr_valid = 1'b1; in_wr_addr = a; in_wr_data = d;
    @(negedge clk); in_wr_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 rdata", reg_rdata, 32'h0);
    reg_read(12'h820, v); check("R1 target lo", v, 32'h0);
    reg_read(12'h830, v); check("R1 status0", v, 32'h0);
    reg_read(12'h834, v); check("R1 enable1", v, 32'h0);
  endtask

  task automatic t_target();
    logic [31:0] v;
    reg_write(12'h820, TGT[31:0]);
    reg_write(12'h824, TGT[63:32]);
    reg_read(12'h820, v); check("R2 target lo", v, TGT[31:0]);
    reg_read(12'h824, v); check("R2 target hi", v, TGT[63:32]);
  endtask

  task automatic t_bank_regs();
    logic [31:0] v;
    reg_write(12'h834, 32'hA5A5_0001);
    reg_read(12'h834, v); check("R3 enable1", v, 32'hA5A5_0001);
    reg_write(12'h82C, 32'h1234_5678);
    reg_read(12'h82C, v); check("R3 mask0", v, 32'h1234_5678);
    reg_write(12'h82C, 32'h0);
    reg_read(12'h900, v); check("R11 unmapped", v, 32'h0);
  endtask

  task automatic t_set();
    logic [31:0] v;
    reg_write(12'h828, 32'hFFFF_FFFF);
    reg_write(12'h834, 32'h0000_0005);
    msi_send(TGT, 32'd7);
    @(negedge clk); check("R10 irq after set", 32'(irq), 32'h1);
    reg_read(12'h830, v); check("R4 status0 vec7", v, 32'h0000_0080);
    msi_send(TGT, 32'd34);
    reg_read(12'h83C, v); check("R4 status1 vec34", v, 32'h0000_0004);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    msi_send(TGT, 32'd33);
    reg_read(12'h83C, v); check("R5 disabled vec33", v, 32'h0000_0004);
    msi_send(TGT + 64'd4, 32'd9);
    reg_read(12'h830, v); check("R6 wrong address", v, 32'h0000_0080);
    msi_send(TGT, 32'd64);
    msi_send(TGT, 32'h0100_0009);
    reg_read(12'h830, v); check("R7 out of range bank0", v, 32'h0000_0080);
    reg_read(12'h83C, v); check("R7 out of range bank1", v, 32'h0000_0004);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    reg_write(12'h830, 32'h0000_0001);
    reg_read(12'h830, v); check("R8 zero bits keep", v, 32'h0000_0080);
    reg_write(12'h83C, 32'h0000_0004);
    reg_write(12'h830, 32'h0000_0080);
    reg_read(12'h830, v); check("R8 cleared bank0", v, 32'h0);
    reg_read(12'h83C, v); check("R8 cleared bank1", v, 32'h0);
    check("R10 irq low after clear", 32'(irq), 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    reg_write(12'h82C, 32'h0000_0004);
    msi_send(TGT, 32'd2);
    @(negedge clk); check("R10 masked irq", 32'(irq), 32'h0);
    reg_read(12'h830, v); check("R10 masked status sets", v, 32'h0000_0004);
    reg_write(12'h82C, 32'h0);
    @(negedge clk); check("R10 unmask irq", 32'(irq), 32'h1);
    reg_write(12'h830, 32'h0000_0004);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    msi_send(TGT, 32'd3);
    msi_send(TGT, 32'd5);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h830; reg_wdata = 32'hFFFF_FFFF;
    in_wr_valid = 1'b1; in_wr_addr = TGT; in_wr_data = 32'd3;
    @(negedge clk);
    reg_wr = 1'b0; in_wr_valid = 1'b0;
    reg_read(12'h830, v); check("R9 set wins over clear", v, 32'h0000_0008);
    reg_write(12'h830, 32'hFFFF_FFFF);
    reg_read(12'h830, v); check("R8 final clear", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_target();
    t_bank_regs();
    t_set();
    t_ignored();
    t_w1c();
    t_mask();
    t_collide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule